// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. It takes two register-style operands and a 3-bit operation select, and returns a 32-bit result together with a carry flag and a signed overflow flag. Any immediate operand has already been formed upstream, so both operand inputs are always full-width values.

The datapath is one 1-bit slice instantiated once per bit. Each slice holds a bitwise AND, a bitwise OR, a full adder whose B input passes through an XOR for inversion, and a result selector. The carry chain ripples from bit 0 to the top bit. Subtraction inverts B in every slice and feeds a carry of one into bit 0. The carry into the top slice is compared with the carry out of the top slice to detect signed overflow. A small decoder turns the operation select into slice controls and flag enables.

Top module: `alu_slice_top`

## Requirements
- R1: Select 010 (signed add) gives result = (A + B) mod 2^32 and carry = bit 32 of the 33-bit unsigned sum.
- R2: Select 011 (unsigned add) gives the same result and carry as R1, and overflow is always 0.
- R3: Select 110 (signed subtract) gives result = (A - B) mod 2^32 and carry = bit 32 of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R4: Select 111 (unsigned subtract) gives the same result and carry as R3, and overflow is always 0.
- R5: For select 010, overflow is 1 exactly when A[31] equals B[31] and the result's bit 31 differs from A[31].
- R6: For select 110, overflow is 1 exactly when A[31] differs from B[31] and the result's bit 31 differs from A[31].
- R7: Select 000 gives result = A AND B, with carry and overflow both 0.
- R8: Select 001 gives result = A OR B, with carry and overflow both 0.
- R9: Selects 100 and 101 give a result of zero, with carry and overflow both 0, whatever the operands.
- R10: The outputs follow any change of the inputs without a clock edge. There is no storage in the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand (A) |
| opb | input | 32 | Second operand (B) |
| op | input | 3 | Operation select |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry out of bit 31 for add and subtract, otherwise 0 |
| overflow | output | 1 | Signed overflow for signed add and subtract, otherwise 0 |

## Verification
The block has no register, so every output is due in the same cycle as the stimulus, after only combinational settling. The bench applies operands shortly after a rising clock edge and samples the outputs on the following falling edge. It places no reliance on a latency count. For R10 the bench changes the inputs between two clock edges and samples one nanosecond later, with no edge in between, which shows that no clocked element sits in the path.

// File: rtl/alu_slice_pkg.sv
// Package alu_slice_pkg
// Shared operation codes, result-select codes and the control bundle passed
// from the decoder to the bit slices. Assumes a 3-bit operation select.
package alu_slice_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_ADDU = 3'b011,
        OP_RSV0 = 3'b100,
        OP_RSV1 = 3'b101,
        OP_SUB  = 3'b110,
        OP_SUBU = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        RSEL_AND  = 2'd0,
        RSEL_OR   = 2'd1,
        RSEL_SUM  = 2'd2,
        RSEL_ZERO = 2'd3
    } rsel_e;

    typedef struct packed {
        logic  binv;
        logic  cin;
        rsel_e rsel;
        logic  ovf_en;
        logic  cry_en;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
// Module alu_op_decode
// Turns the 3-bit operation select into slice controls: B inversion, carry
// into bit 0, result selection and the enables for the carry and overflow
// flags. Purely combinational. Assumes the encoding in alu_slice_pkg.
module alu_op_decode
    import alu_slice_pkg::*;
(
    input  logic [2:0] op,
    output alu_ctrl_t  ctrl
);

    // Map each operation select to its control bundle.
    always_comb begin
        ctrl = '{binv: 1'b0, cin: 1'b0, rsel: RSEL_ZERO, ovf_en: 1'b0, cry_en: 1'b0};
        case (op)
            OP_AND:  ctrl.rsel = RSEL_AND;
            OP_OR:   ctrl.rsel = RSEL_OR;
            OP_ADD: begin
                ctrl.rsel   = RSEL_SUM;
                ctrl.ovf_en = 1'b1;
                ctrl.cry_en = 1'b1;
            end
            OP_ADDU: begin
                ctrl.rsel   = RSEL_SUM;
                ctrl.cry_en = 1'b1;
            end
            OP_SUB: begin
                ctrl.binv   = 1'b1;
                ctrl.cin    = 1'b1;
                ctrl.rsel   = RSEL_SUM;
                ctrl.ovf_en = 1'b1;
                ctrl.cry_en = 1'b1;
            end
            OP_SUBU: begin
                ctrl.binv   = 1'b1;
                ctrl.cin    = 1'b1;
                ctrl.rsel   = RSEL_SUM;
                ctrl.cry_en = 1'b1;
            end
            default: ctrl.rsel = RSEL_ZERO;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module alu_bit_slice
// One bit of the ALU: AND, OR, and a full adder whose B input is XORed with
// an invert control, followed by a result selector. The carry-out goes to
// the next slice up. Purely combinational.
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  binv,
    input  logic  cin,
    input  rsel_e rsel,
    output logic  r,
    output logic  cout
);

    logic b_eff;
    logic sum;

    // Conditional inversion of B for subtraction.
    assign b_eff = b ^ binv;

    // Full adder: sum and majority carry.
    assign sum  = a ^ b_eff ^ cin;
    assign cout = (a & cin) | (b_eff & cin) | (a & b_eff);

    // Pick the slice result.
    always_comb begin
        case (rsel)
            RSEL_AND: r = a & b;
            RSEL_OR:  r = a | b;
            RSEL_SUM: r = sum;
            default:  r = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_slice_top.sv
// Module alu_slice_top
// W-bit ALU made of W replicated bit slices with a ripple carry chain. The
// decoder drives every slice with the same controls. The top slice's carry-in
// and carry-out produce the overflow flag. Purely combinational: it has no
// clock and no reset.
module alu_slice_top
    import alu_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   op,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow
);

    localparam int MSB = W - 1;

    alu_ctrl_t ctrl;
    logic      c_msb_in;
    logic      c_msb_out;

    alu_op_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    // One slice per bit, each carry-in taken from the slice below.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic c_in;
        logic c_out;
        if (i == 0) begin : g_lsb
            assign c_in = ctrl.cin;
        end else begin : g_up
            assign c_in = g_bit[i-1].c_out;
        end
        alu_bit_slice u_slice (
            .a    (opa[i]),
            .b    (opb[i]),
            .binv (ctrl.binv),
            .cin  (c_in),
            .rsel (ctrl.rsel),
            .r    (result[i]),
            .cout (c_out)
        );
    end

    // Tap the carries around the most significant slice.
    assign c_msb_in  = g_bit[MSB].c_in;
    assign c_msb_out = g_bit[MSB].c_out;

    // Flags, gated by the operation class.
    assign carry_out = ctrl.cry_en & c_msb_out;
    assign overflow  = ctrl.ovf_en & (c_msb_in ^ c_msb_out);

endmodule

// File: rtl/alu_slice_chk.sv
// Module alu_slice_chk
// Checker bound to alu_slice_top. It compares the outputs with arithmetic
// models written independently of the slice structure. Because the block has
// no clock, it uses immediate assertions on settled values.
module alu_slice_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [2:0]   op,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow
);

    logic [W:0] add_ref;
    logic [W:0] sub_ref;

    // Wide reference sums.
    assign add_ref = {1'b0, opa} + {1'b0, opb};
    assign sub_ref = {1'b0, opa} - {1'b0, opb};

    // Output checks per operation class.
    always_comb begin
        if (op == 3'b010 || op == 3'b011) begin
            a_r1_add_sum: assert ({carry_out, result} == add_ref)
                else $error("add sum/carry mismatch");
        end
        if (op == 3'b011 || op == 3'b111) begin
            a_r2_no_overflow: assert (!overflow)
                else $error("unsigned op raised overflow");
        end
        if (op == 3'b110 || op == 3'b111) begin
            a_r3_sub_diff: assert (result == sub_ref[W-1:0] && carry_out == (opa >= opb))
                else $error("sub result/carry mismatch");
        end
        if (op == 3'b010) begin
            a_r5_add_ovf: assert (overflow == ((opa[W-1] == opb[W-1]) && (result[W-1] != opa[W-1])))
                else $error("add overflow mismatch");
        end
        if (op == 3'b110) begin
            a_r6_sub_ovf: assert (overflow == ((opa[W-1] != opb[W-1]) && (result[W-1] != opa[W-1])))
                else $error("sub overflow mismatch");
        end
        if (op == 3'b000 || op == 3'b001) begin
            a_r7_logic_flags: assert (!carry_out && !overflow)
                else $error("logic op raised a flag");
        end
        if (op == 3'b100 || op == 3'b101) begin
            a_r9_reserved_zero: assert (result == '0 && !carry_out && !overflow)
                else $error("reserved op not zero");
        end
    end

endmodule

bind alu_slice_top alu_slice_chk #(.W(W)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .op        (op),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/test_alu_slice_top.sv
// Directed bench for alu_slice_top. Each scenario task drives operands and
// compares the outputs with values worked out from the requirements.
module test_alu_slice_top;

    logic        clk = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [2:0]  op  = 3'b000;
    logic [31:0] result;
    logic        carry_out;
    logic        overflow;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    alu_slice_top #(.W(32)) i_alu_slice_top (
        .opa       (opa),
        .opb       (opb),
        .op        (op),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Expected outputs, derived from the requirements.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] o,
                         output logic [31:0] r, output logic c, output logic v);
        logic [32:0] s;
        r = '0; c = 1'b0; v = 1'b0;
        case (o)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010, 3'b011: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; c = s[32];
                v = (o == 3'b010) && (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'b110, 3'b111: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s[31:0]; c = s[32];
                v = (o == 3'b110) && (a[31] != b[31]) && (r[31] != a[31]);
            end
            default: r = '0;
        endcase
    endtask

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'b000: return "R7";
            3'b001: return "R8";
            3'b010: return "R1/R5";
            3'b011: return "R2";
            3'b110: return "R3/R6";
            3'b111: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req, input logic [31:0] er, input logic ec, input logic ev);
        checks++;
        if (result !== er || carry_out !== ec || overflow !== ev) begin
            errors++;
            $display("FAIL %s: op=%b a=%h b=%h got r=%h c=%b v=%b exp r=%h c=%b v=%b",
                     req, op, opa, opb, result, carry_out, overflow, er, ec, ev);
        end
    endtask

    // Drive after a rising edge, sample at the falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] o);
        @(posedge clk);
        #1;
        opa = a; opb = b; op = o;
        @(negedge clk);
    endtask

    task automatic run_lit(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [2:0] o, input logic [31:0] er, input logic ec,
                           input logic ev);
        apply(a, b, o);
        compare(req, er, ec, ev);
    endtask

    task automatic t_idle();
        run_lit("R7 idle zeros", 32'h0, 32'h0, 3'b000, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_add_corners();
        run_lit("R1 simple add", 32'd7, 32'd5, 3'b010, 32'd12, 1'b0, 1'b0);
        run_lit("R1 carry wrap", 32'hFFFF_FFFF, 32'h1, 3'b010, 32'h0, 1'b1, 1'b0);
        run_lit("R5 positive overflow", 32'h7FFF_FFFF, 32'h1, 3'b010, 32'h8000_0000, 1'b0, 1'b1);
        run_lit("R5 negative overflow", 32'h8000_0000, 32'h8000_0000, 3'b010, 32'h0, 1'b1, 1'b1);
        run_lit("R2 unsigned no overflow", 32'h7FFF_FFFF, 32'h1, 3'b011, 32'h8000_0000, 1'b0, 1'b0);
        run_lit("R2 unsigned carry", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, 32'hFFFF_FFFE, 1'b1, 1'b0);
    endtask

    task automatic t_sub_corners();
        run_lit("R3 equal operands", 32'd5, 32'd5, 3'b110, 32'h0, 1'b1, 1'b0);
        run_lit("R3 borrow", 32'h0, 32'h1, 3'b110, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_lit("R6 negative overflow", 32'h8000_0000, 32'h1, 3'b110, 32'h7FFF_FFFF, 1'b1, 1'b1);
        run_lit("R6 positive overflow", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, 32'h8000_0000, 1'b0, 1'b1);
        run_lit("R4 unsigned no overflow", 32'h8000_0000, 32'h1, 3'b111, 32'h7FFF_FFFF, 1'b1, 1'b0);
        run_lit("R4 unsigned borrow", 32'd3, 32'd9, 3'b111, 32'hFFFF_FFFA, 1'b0, 1'b0);
    endtask

    task automatic t_logic();
        run_lit("R7 and", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b000, 32'h00F0_1200, 1'b0, 1'b0);
        run_lit("R7 and all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_lit("R8 or", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b001, 32'hFFF0_FF34, 1'b0, 1'b0);
    endtask

    task automatic t_reserved();
        run_lit("R9 code 100", 32'hFFFF_FFFF, 32'h1, 3'b100, 32'h0, 1'b0, 1'b0);
        run_lit("R9 code 101", 32'h8000_0000, 32'h8000_0000, 3'b101, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_comb();
        logic [31:0] er;
        logic ec, ev;
        apply(32'd100, 32'd1, 3'b010);
        #1;
        opa = 32'hFFFF_FFFF; opb = 32'h2; op = 3'b110;
        #1;
        model(opa, opb, op, er, ec, ev);
        compare("R10 no clock edge", er, ec, ev);
    endtask

    task automatic t_random();
        logic [31:0] er;
        logic ec, ev;
        logic [2:0] ops [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = $urandom();
            if (n % 7 == 0) b = a;
            if (n % 11 == 0) a = {a[31], 31'h7FFF_FFFF};
            apply(a, b, ops[n % 6]);
            model(opa, opb, op, er, ec, ev);
            compare(tag_of(op), er, ec, ev);
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        t_idle();
        t_add_corners();
        t_sub_corners();
        t_logic();
        t_reserved();
        t_comb();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule